// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block holds the digital side of an 8-bit successive-approximation converter. Software programs a control register that holds an analog channel number, a ladder supply connect bit and an interrupt enable. A conversion starts when software writes that register with its completion flag at 0. The block then clears its result register and works through the bits from the most significant down. For each bit it sets the bit, drives the code to the resistor ladder, waits for the analog side to settle, and samples a single comparator bit to decide whether the bit stays set.

After the last decision the completion flag and the interrupt request flag rise together. An interrupt line goes out while the request flag and the enable are both set. The request flag stays set until software clears it; a new start leaves it alone. The channel select and ladder connect outputs are registered. They take new values only when a conversion starts. A start written during a conversion restarts it from the clear step. The result register can be read at any time and returns the code currently on the ladder.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, trial_o, chan_sel_o, ladder_en_o and irq_o are 0, and the control register reads 0x00.
- R2: The control register is at address 0. Its bits are: [2:0] channel, [3] ladder connect, [4] completion flag, [5] interrupt enable, [6] interrupt request, [7] reads 0. A write to address 0 with bit 4 at 0 is a start. One cycle after a start, trial_o is 0x00 and the completion flag reads 0. A write with bit 4 at 1 starts nothing.
- R3: One cycle after the clear, trial_o is 0x80. Bits are then tested from 7 down to 0, and each trial lasts 6 cycles. The comparator is sampled at the clock edge that ends the 6th cycle of the trial, and the next trial code appears at that same edge.
- R4: When comp_i is 1 at its sample edge, the bit under test stays 1, and when comp_i is 0 the bit is cleared. The final code is therefore the largest n whose threshold lies below the input, where the threshold is 0 for n=0 and (n-0.5)/256 of full scale otherwise.
- R5: The completion flag and the interrupt request flag go to 1 at the same edge, exactly 50 cycles after the start edge.
- R6: Writing 1 to bit 6 of the control register clears the interrupt request flag, and writing 0 leaves it unchanged. A start does not clear the flag. If a clear and a completion fall on the same edge, the completion wins.
- R7: A start written while a conversion is running restarts it from the clear step, and its completion comes 50 cycles after the restart edge.
- R8: A read of address 1 returns the current trial code, both during a conversion and after it.
- R9: chan_sel_o and ladder_en_o are loaded from the written bits [2:0] and [3] only at a start edge. Writes that are not starts change only the value read back from the control register.
- R10: irq_o is 1 exactly when the request flag and the enable bit are both 1, and the enable takes effect one cycle after it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address (0 control, 1 result, read-only) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| comp_i | input | 1 | Comparator: 1 when the input is above the ladder threshold |
| trial_o | output | 8 | Trial code driven to the ladder |
| chan_sel_o | output | 3 | Analog channel select |
| ladder_en_o | output | 1 | Ladder supply connect |
| irq_o | output | 1 | Interrupt request |

## Verification
The case hardest to reach is a restart in the middle of a trial. It must throw away a partly built code, reload the channel, and still complete exactly 50 cycles after the restart edge. The bench issues a second start about twenty cycles into a conversion, on a channel whose input differs. The every-cycle reference model then shows whether any bit decision or counter state survives the restart. Input levels sit on and next to threshold boundaries at both ends of the scale, where a wrong sampling cycle or a reversed comparison changes one bit.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned CHAN_W = 3;

  localparam int unsigned LAD_BIT  = 3;
  localparam int unsigned DONE_BIT = 4;
  localparam int unsigned IEN_BIT  = 5;
  localparam int unsigned IRQ_BIT  = 6;

  localparam logic CTRL_ADDR = 1'b0;
  localparam logic RES_ADDR  = 1'b1;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_TRIAL  = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_e;
endpackage

// File: rtl/sar_adc_regs.sv
module sar_adc_regs
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [RES_W-1:0]  result_i,
  input  logic              finish_i,
  output logic              start_o,
  output logic [CHAN_W-1:0] chan_sh_o,
  output logic              lad_sh_o,
  output logic              irq_en_o,
  output logic              irq_flag_o,
  output logic              done_o
);
  logic ctrl_wr;
  logic unused_bits;

  assign ctrl_wr     = wr_en_i && (wr_addr_i == CTRL_ADDR);
  assign start_o     = ctrl_wr && !wr_data_i[DONE_BIT];
  assign unused_bits = wr_data_i[REG_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_sh_o <= '0;
      lad_sh_o  <= 1'b0;
      irq_en_o  <= 1'b0;
    end else if (ctrl_wr) begin
      chan_sh_o <= wr_data_i[CHAN_W-1:0];
      lad_sh_o  <= wr_data_i[LAD_BIT];
      irq_en_o  <= wr_data_i[IEN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       done_o <= 1'b0;
    else if (start_o)  done_o <= 1'b0;
    else if (finish_i) done_o <= 1'b1;
  end

  // completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             irq_flag_o <= 1'b0;
    else if (finish_i && !start_o)           irq_flag_o <= 1'b1;
    else if (ctrl_wr && wr_data_i[IRQ_BIT])  irq_flag_o <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == RES_ADDR) begin
      rd_data_o[RES_W-1:0] = result_i;
    end else begin
      rd_data_o[CHAN_W-1:0] = chan_sh_o;
      rd_data_o[LAD_BIT]    = lad_sh_o;
      rd_data_o[DONE_BIT]   = done_o;
      rd_data_o[IEN_BIT]    = irq_en_o;
      rd_data_o[IRQ_BIT]    = irq_flag_o;
    end
  end
endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SETTLE_CYC = 5,
  localparam int unsigned IDX_W     = (RES_W > 1) ? $clog2(RES_W) : 1,
  localparam int unsigned CNT_W     = $clog2(SETTLE_CYC + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_msb_o,
  output logic             sample_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             finish_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign load_msb_o = (state_q == ST_SETUP);
  assign sample_o   = (state_q == ST_TRIAL) && (cnt_q == CNT_LAST);
  assign finish_o   = (state_q == ST_FINISH);
  assign idx_o      = idx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    if (start_i) begin
      state_d = ST_SETUP;
      cnt_d   = '0;
      idx_d   = IDX_TOP;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_SETUP: begin
          state_d = ST_TRIAL;
          cnt_d   = '0;
          idx_d   = IDX_TOP;
        end
        ST_TRIAL: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            if (idx_q == '0) state_d = ST_FINISH;
            else             idx_d   = idx_q - 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_FINISH: state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
    end
  end
endmodule

// File: rtl/sar_adc_sar.sv
module sar_adc_sar #(
  parameter int unsigned RES_W  = 8,
  localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_msb_i,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             comp_i,
  output logic [RES_W-1:0] code_o
);
  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    logic bit_q, bit_d;
    logic is_test, is_next;

    assign is_test = sample_i && (int'(idx_i) == i);
    assign is_next = sample_i && (int'(idx_i) == i + 1);

    always_comb begin
      bit_d = bit_q;
      if (clear_i)                               bit_d = 1'b0;
      else if (load_msb_i && (i == RES_W - 1))   bit_d = 1'b1;
      else if (is_test)                          bit_d = bit_q & comp_i;
      else if (is_next)                          bit_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= bit_d;
    end

    assign code_o[i] = bit_q;
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SETTLE_CYC = 5,
  localparam int unsigned IDX_W     = (RES_W > 1) ? $clog2(RES_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic              comp_i,
  output logic [RES_W-1:0]  trial_o,
  output logic [CHAN_W-1:0] chan_sel_o,
  output logic              ladder_en_o,
  output logic              irq_o
);
  logic              start;
  logic              load_msb;
  logic              sample;
  logic              finish;
  logic [IDX_W-1:0]  idx;
  logic [CHAN_W-1:0] chan_sh;
  logic              lad_sh;
  logic              irq_en;
  logic              irq_flag;
  logic              done_flag;

  sar_adc_regs #(.RES_W(RES_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .result_i   (trial_o),
    .finish_i   (finish),
    .start_o    (start),
    .chan_sh_o  (chan_sh),
    .lad_sh_o   (lad_sh),
    .irq_en_o   (irq_en),
    .irq_flag_o (irq_flag),
    .done_o     (done_flag)
  );

  sar_adc_seq #(.RES_W(RES_W), .SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .load_msb_o (load_msb),
    .sample_o   (sample),
    .idx_o      (idx),
    .finish_o   (finish)
  );

  sar_adc_sar #(.RES_W(RES_W)) u_sar (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start),
    .load_msb_i (load_msb),
    .sample_i   (sample),
    .idx_i      (idx),
    .comp_i     (comp_i),
    .code_o     (trial_o)
  );

  // analog-side controls change only at a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_sel_o  <= '0;
      ladder_en_o <= 1'b0;
    end else if (start) begin
      chan_sel_o  <= wr_data_i[CHAN_W-1:0];
      ladder_en_o <= wr_data_i[LAD_BIT];
    end
  end

  assign irq_o = irq_flag & irq_en;

  logic unused_shadow;
  assign unused_shadow = ^{chan_sh, lad_sh};
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk
  import sar_adc_pkg::*;
#(
  parameter int unsigned RES_W      = 8,
  parameter int unsigned SETTLE_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              load_msb_i,
  input logic              done_i,
  input logic              irq_flag_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic [RES_W-1:0]  trial_i,
  input logic [CHAN_W-1:0] chan_sel_i,
  input logic              ladder_en_i
);
  localparam int unsigned CONV_CYC = 2 + RES_W * (SETTLE_CYC + 1);
  localparam logic [RES_W-1:0] MSB_CODE = {1'b1, {(RES_W-1){1'b0}}};

  logic [15:0] since_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 since_start <= 16'hffff;
    else if (start_i)            since_start <= '0;
    else if (since_start != '1)  since_start <= since_start + 1'b1;
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (trial_i == '0)); // R2
  AST_START_DONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_i); // R2
  AST_MSB_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_msb_i && !start_i) |=> (trial_i == MSB_CODE)); // R3
  AST_DONE_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> irq_flag_i); // R5
  AST_CONV_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (since_start == 16'(CONV_CYC))); // R5
  AST_START_KEEPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wr_data_i[IRQ_BIT] && irq_flag_i) |=> irq_flag_i); // R6
  AST_ANALOG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(chan_sel_i) && $stable(ladder_en_i))); // R9
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_W(RES_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start),
  .load_msb_i  (load_msb),
  .done_i      (done_flag),
  .irq_flag_i  (irq_flag),
  .wr_data_i   (wr_data_i),
  .trial_i     (trial_o),
  .chan_sel_i  (chan_sel_o),
  .ladder_en_i (ladder_en_o)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       comp;
  logic [7:0] trial;
  logic [2:0] chan_sel;
  logic       ladder_en;
  logic       irq;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int vin [8];   // input level per channel, in units of full scale / 512

  always #4 clk = ~clk;

  sar_adc_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .comp_i(comp), .trial_o(trial), .chan_sel_o(chan_sel),
    .ladder_en_o(ladder_en), .irq_o(irq)
  );

  function automatic int thr(int n);
    return (n == 0) ? 0 : 2 * n - 1;
  endfunction

  function automatic int expect_code(int v);
    int best = 0;
    for (int n = 1; n < 256; n++) if (thr(n) < v) best = n;
    return best;
  endfunction

  assign comp = (thr(int'(trial)) < vin[chan_sel]);

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // behavioural reference model
  int       m_k;
  bit       m_busy, m_done, m_irq, m_en, m_lad, m_lads;
  int       m_res, m_chan, m_chs;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_k = 0; m_busy = 0; m_done = 0; m_irq = 0; m_en = 0;
      m_lad = 0; m_lads = 0; m_res = 0; m_chan = 0; m_chs = 0;
    end else begin
      bit wr_c, st, clr, fin;
      wr_c = wr_en && (wr_addr == 1'b0);
      st   = wr_c && !wr_data[4];
      clr  = wr_c && wr_data[6];
      fin  = 0;
      if (st) begin
        m_res = 0; m_k = 0; m_busy = 1; m_done = 0;
        m_chan = wr_data[2:0]; m_lad = wr_data[3];
      end else if (m_busy) begin
        m_k++;
        if (m_k == 1) m_res = 8'h80;
        else if (m_k >= 7 && m_k <= 49 && (m_k - 7) % 6 == 0) begin
          int b;
          b = 7 - (m_k - 7) / 6;
          if (!(thr(m_res) < vin[m_chan])) m_res = m_res & ~(1 << b);
          if (b > 0) m_res = m_res | (1 << (b - 1));
        end else if (m_k == 50) begin
          m_done = 1; m_busy = 0; fin = 1;
        end
      end
      if (wr_c) begin
        m_chs = wr_data[2:0]; m_lads = wr_data[3]; m_en = wr_data[5];
      end
      if (clr) m_irq = 0;
      if (fin) m_irq = 1;
    end
  end

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R3 R4 trial code", trial, m_res);
      chk("R9 channel out", chan_sel, m_chan);
      chk("R9 ladder out", ladder_en, m_lad);
      chk("R10 irq out", irq, m_irq && m_en);
      if (rd_addr)
        chk("R8 result read", rd_data, m_res);
      else
        chk("R2 R6 ctrl read", rd_data,
            {1'b0, m_irq, m_en, m_done, m_lads, m_chs[2:0]});
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr_ctrl(logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns cycles from the start edge until done is visible (done at edge 50 -> 51)
  task automatic wait_done(output int n);
    rd_addr = 1'b0;
    n = 1;
    while (!rd_data[4] && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic convert(int ch, int v, bit en);
    int n;
    vin[ch] = v;
    wr_ctrl({2'b00, en, 1'b0, 1'b1, 3'(ch)});
    wait_done(n);
    chk("R5 completion latency", n, 51);
    rd_addr = 1'b1;
    #1;
    chk("R4 final code", rd_data, expect_code(v));
    rd_addr = 1'b0;
  endtask

  initial begin
    int n;
    for (int i = 0; i < 8; i++) vin[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 trial reset", trial, 0);
    chk("R1 chan reset", chan_sel, 0);
    chk("R1 ladder reset", ladder_en, 0);
    chk("R1 irq reset", irq, 0);
    chk("R1 ctrl reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    convert(0, 0, 1'b0);
    convert(1, 1, 1'b0);
    convert(2, 2, 1'b0);
    convert(3, 3, 1'b0);
    convert(4, 255, 1'b0);
    convert(5, 256, 1'b0);
    convert(6, 510, 1'b0);
    convert(7, 511, 1'b0);
    convert(2, 300, 1'b1);
    chk("R10 irq with enable", irq, 1);

    // R6: start with bit6=0 keeps the flag, W1C clears it
    wr_ctrl(8'h0a);
    chk("R6 start keeps irq", rd_data[6], 1);
    chk("R10 irq disabled", irq, 0);
    wait_done(n);
    wr_ctrl(8'h50);
    chk("R6 w1c clears irq", rd_data[6], 0);
    wr_ctrl(8'h10);
    chk("R2 no start when bit4 set", rd_data[4], 1);

    // R9 + R7: mid-conversion channel write, then restart
    vin[6] = 137; vin[1] = 402;
    wr_ctrl(8'h0e);
    repeat (10) @(negedge clk);
    wr_ctrl(8'h11);
    chk("R9 chan held without start", chan_sel, 6);
    chk("R9 ladder held without start", ladder_en, 1);
    repeat (8) @(negedge clk);
    wr_ctrl(8'h29);
    chk("R7 restart loads channel", chan_sel, 1);
    wait_done(n);
    chk("R7 restart latency", n, 51);
    rd_addr = 1'b1;
    #1;
    chk("R7 restart code", rd_data, expect_code(402));
    rd_addr = 1'b0;
    chk("R10 irq after restart", irq, 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule